// File: doc/BRIEF.md
# DDR Bank Timing Guard

This block watches the command stream that a memory controller sends to a four-bank DDR SDRAM. It keeps the open or closed state of each bank and enforces the minimum spacing between commands. The spacing rules are activate-to-column, precharge-to-activate, row active time, row cycle, activate-to-activate across banks, write recovery and the mode-register lockout. It also detects rows that have been held open past the maximum row active time. Each limit is given as a parameter in picoseconds and turned into a whole number of clocks by rounding up. The maximum row active time is the one exception: it is rounded down.

A scheduler presents a candidate command on `cmd_op`, `cmd_bank` and `cmd_ap`. In the same cycle, `cmd_legal` reports whether issuing it now would break any rule. The verdict is combinational and does not depend on `cmd_valid`, so the scheduler can stall by holding `cmd_valid` low until `cmd_legal` rises. Back-pressure is advisory: the block never refuses a command. Any cycle with `cmd_valid` high counts as an issued command, and the tracked state is updated as if the DRAM executed it. If an illegal command is issued anyway, the matching reason bit is set in a sticky vector. That bit stays set until `viol_clr` is pulsed.

Top module: `ddr_bank_timing_guard`

## Requirements
- R1: `cmd_legal` is high exactly when the presented command breaks no rule, with or without `cmd_valid`. A command with `cmd_valid` high is always taken and updates bank state, legal or not. Opcodes: 0 no-op, 1 activate, 2 read, 3 write, 4 precharge (`cmd_ap`=1 means all banks), 5 mode-register set; 6 and 7 act as no-ops.
- R2: Each minimum limit in clocks is the ceiling of its picosecond figure divided by `CLK_PS`. With the defaults (7.5 ns clock) these are: activate-to-column 3, precharge-to-activate 3, row active 6, row cycle 9, cross-bank activate 2, write recovery 2.
- R3: A read or write to an open bank fewer than the activate-to-column clocks after its activate is illegal (reason bit 0).
- R4: An activate fewer than the precharge clocks after that bank was closed is illegal (reason bit 1).
- R5: A precharge that would close a bank fewer than the row-active clocks after its activate is illegal (reason bit 2).
- R6: An activate fewer than the row-cycle clocks after the previous activate of the same bank is illegal (reason bit 3).
- R7: An activate fewer than the cross-bank clocks after any activate is illegal (reason bit 4).
- R8: A precharge that would close a bank fewer than burst-length plus write-recovery clocks after a write to it is illegal (reason bit 5).
- R9: Any non-no-op command within `MRD_CLK` clocks of a mode-register set is illegal, and so is a mode-register set while any bank is open (reason bit 6).
- R10: A read or write to a closed bank, or an activate to an open bank, is illegal (reason bit 7).
- R11: A read or write with `cmd_ap`=1 closes its bank at once. The bank may be activated again only burst-length plus precharge clocks later.
- R12: A bank held open for more than floor(`T_RASMAX_PS`/`CLK_PS`) clocks sets reason bit 8.
- R13: Reason bits are set only by issued illegal commands or by R12. They hold until `viol_clr` is pulsed and are zero after reset. `viol_flag` is high whenever any bit is set.
- R14: A precharge checks R5 and R8 only against the banks it actually closes. Precharging a closed bank is legal and starts no precharge timer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Presented command is issued this cycle |
| cmd_op | input | 3 | Command opcode (see R1) |
| cmd_bank | input | 2 | Target bank |
| cmd_ap | input | 1 | Auto-precharge on read/write; all-banks on precharge |
| cmd_legal | output | 1 | Presented command breaks no timing or state rule |
| viol_clr | input | 1 | Clears the sticky reason vector |
| viol_flag | output | 1 | Any sticky reason bit set |
| viol_reason | output | 9 | Sticky one-bit-per-rule violation reasons |

## Verification
The bench probes each limit one clock before and exactly at its boundary. If ceilings were replaced by truncation, the 8.67-clock row cycle would open one cycle early. It exercises a write with auto-precharge, where a design that ignored the burst length would accept the re-activate too soon, or would still treat the bank as open for reads. It issues an all-banks precharge while only one bank is still young, to catch a design that checks only the addressed bank or that starts a precharge timer on a bank that was already closed. It also holds a row open for the full maximum window, where an off-by-one in the age counter shifts the flag by one cycle.

// File: rtl/ddr_tg_pkg.sv
package ddr_tg_pkg;

  typedef enum logic [2:0] {
    OP_NOP = 3'd0,
    OP_ACT = 3'd1,
    OP_RD  = 3'd2,
    OP_WR  = 3'd3,
    OP_PRE = 3'd4,
    OP_MRS = 3'd5,
    OP_RS6 = 3'd6,
    OP_RS7 = 3'd7
  } op_e;

  localparam int RSN_RCD    = 0;
  localparam int RSN_RP     = 1;
  localparam int RSN_RAS    = 2;
  localparam int RSN_RC     = 3;
  localparam int RSN_RRD    = 4;
  localparam int RSN_WR     = 5;
  localparam int RSN_MODE   = 6;
  localparam int RSN_STATE  = 7;
  localparam int RSN_RASMAX = 8;
  localparam int RSN_W      = 9;

  function automatic int clk_ceil(input longint ps, input longint per);
    return int'((ps + per - 1) / per);
  endfunction

  function automatic int clk_floor(input longint ps, input longint per);
    return int'(ps / per);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // countdown load so that a limit of n clocks frees the n-th cycle after issue
  function automatic int load_of(input int n);
    return (n > 0) ? n - 1 : 0;
  endfunction

endpackage

// File: rtl/ddr_tg_bank.sv
module ddr_tg_bank
  import ddr_tg_pkg::*;
#(
  parameter int RCD_C    = 3,
  parameter int RP_C     = 3,
  parameter int RAS_C    = 6,
  parameter int RC_C     = 9,
  parameter int WR_C     = 2,
  parameter int BURST_C  = 2,
  parameter int RASMAX_C = 16000,
  parameter int CNT_W    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_act,
  input  logic ev_wr,
  input  logic ev_ap,
  input  logic ev_close,
  output logic open_o,
  output logic rcd_busy_o,
  output logic rp_busy_o,
  output logic ras_busy_o,
  output logic rc_busy_o,
  output logic wr_busy_o,
  output logic ras_over_o
);

  localparam int AGE_W = $clog2(RASMAX_C + 2);
  localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(load_of(RCD_C));
  localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(load_of(RP_C));
  localparam logic [CNT_W-1:0] LD_APRP = CNT_W'(load_of(BURST_C + RP_C));
  localparam logic [CNT_W-1:0] LD_RAS  = CNT_W'(load_of(RAS_C));
  localparam logic [CNT_W-1:0] LD_RC   = CNT_W'(load_of(RC_C));
  localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(load_of(BURST_C + WR_C));
  localparam logic [AGE_W-1:0] AGE_SAT = AGE_W'(RASMAX_C + 1);
  localparam logic [AGE_W-1:0] AGE_LIM = AGE_W'(RASMAX_C);

  logic [CNT_W-1:0] rcd_q, rp_q, ras_q, rc_q, wr_q;
  logic [AGE_W-1:0] age_q;
  logic             open_q;

  function automatic logic [CNT_W-1:0] dec(input logic [CNT_W-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rcd_q  <= '0;
      rp_q   <= '0;
      ras_q  <= '0;
      rc_q   <= '0;
      wr_q   <= '0;
      age_q  <= '0;
      open_q <= 1'b0;
    end else begin
      rcd_q <= ev_act ? LD_RCD : dec(rcd_q);
      ras_q <= ev_act ? LD_RAS : dec(ras_q);
      rc_q  <= ev_act ? LD_RC  : dec(rc_q);
      wr_q  <= ev_wr  ? LD_WR  : dec(wr_q);
      if (ev_ap)         rp_q <= LD_APRP;
      else if (ev_close) rp_q <= LD_RP;
      else               rp_q <= dec(rp_q);
      if (ev_act)                  open_q <= 1'b1;
      else if (ev_ap || ev_close)  open_q <= 1'b0;
      if (ev_act)                  age_q <= AGE_W'(1);
      else if (!open_q)            age_q <= '0;
      else if (age_q != AGE_SAT)   age_q <= age_q + 1'b1;
    end
  end

  assign open_o     = open_q;
  assign rcd_busy_o = (rcd_q != '0);
  assign rp_busy_o  = (rp_q  != '0);
  assign ras_busy_o = (ras_q != '0);
  assign rc_busy_o  = (rc_q  != '0);
  assign wr_busy_o  = (wr_q  != '0);
  assign ras_over_o = open_q && (age_q > AGE_LIM);

  // R10: an activate leaves the bank open on the next cycle
  assert_act_opens_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> open_o);

  // R4: closing a bank blocks its next activate for at least one cycle when tRP > 1
  assert_close_starts_rp_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_close && !ev_act) |=> (!open_o && (rp_busy_o || RP_C < 2)));

  // R12: a fresh activate restarts the row age
  assert_age_restart_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act |=> !ras_over_o);

endmodule

// File: rtl/ddr_tg_global.sv
module ddr_tg_global
  import ddr_tg_pkg::*;
#(
  parameter int RRD_C = 2,
  parameter int MRD_C = 2,
  parameter int CNT_W = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ev_act_any,
  input  logic ev_mrs,
  output logic rrd_busy_o,
  output logic mrd_busy_o
);

  localparam logic [CNT_W-1:0] LD_RRD = CNT_W'(load_of(RRD_C));
  localparam logic [CNT_W-1:0] LD_MRD = CNT_W'(load_of(MRD_C));

  logic [CNT_W-1:0] rrd_q, mrd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rrd_q <= '0;
      mrd_q <= '0;
    end else begin
      if (ev_act_any)        rrd_q <= LD_RRD;
      else if (rrd_q != '0)  rrd_q <= rrd_q - 1'b1;
      if (ev_mrs)            mrd_q <= LD_MRD;
      else if (mrd_q != '0)  mrd_q <= mrd_q - 1'b1;
    end
  end

  assign rrd_busy_o = (rrd_q != '0);
  assign mrd_busy_o = (mrd_q != '0);

  // R9: a mode-register set locks out the following cycle when MRD > 1
  assert_mrs_lockout_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_mrs |=> (mrd_busy_o || MRD_C < 2));

  // R7: an activate blocks the next one when the cross-bank limit exceeds one clock
  assert_act_spacing_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_act_any |=> (rrd_busy_o || RRD_C < 2));

endmodule

// File: rtl/ddr_tg_sticky.sv
module ddr_tg_sticky #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] set_i,
  output logic [W-1:0] reason_o,
  output logic         flag_o
);

  logic [W-1:0] reason_q;

  always_ff @(posedge clk) begin
    if (!rst_n) reason_q <= '0;
    else        reason_q <= (clr ? '0 : reason_q) | set_i;
  end

  assign reason_o = reason_q;
  assign flag_o   = |reason_q;

  // R13: without a clear, no reason bit ever falls
  assert_sticky_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((reason_q & $past(reason_q)) == $past(reason_q)));

endmodule

// File: rtl/ddr_bank_timing_guard.sv
module ddr_bank_timing_guard
  import ddr_tg_pkg::*;
#(
  parameter int NBANK        = 4,
  parameter int CLK_PS       = 7500,
  parameter int T_RCD_PS     = 20000,
  parameter int T_RP_PS      = 20000,
  parameter int T_RAS_PS     = 45000,
  parameter int T_RASMAX_PS  = 120000000,
  parameter int T_RC_PS      = 65000,
  parameter int T_RRD_PS     = 15000,
  parameter int T_WR_PS      = 15000,
  parameter int MRD_CLK      = 2,
  parameter int BURST_CLK    = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cmd_valid,
  input  logic [2:0]                 cmd_op,
  input  logic [$clog2(NBANK)-1:0]   cmd_bank,
  input  logic                       cmd_ap,
  output logic                       cmd_legal,
  input  logic                       viol_clr,
  output logic                       viol_flag,
  output logic [RSN_W-1:0]           viol_reason
);

  localparam int BANK_W   = $clog2(NBANK);
  localparam int RCD_C    = clk_ceil(T_RCD_PS, CLK_PS);
  localparam int RP_C     = clk_ceil(T_RP_PS, CLK_PS);
  localparam int RAS_C    = clk_ceil(T_RAS_PS, CLK_PS);
  localparam int RC_C     = clk_ceil(T_RC_PS, CLK_PS);
  localparam int RRD_C    = clk_ceil(T_RRD_PS, CLK_PS);
  localparam int WR_C     = clk_ceil(T_WR_PS, CLK_PS);
  localparam int RASMAX_C = clk_floor(T_RASMAX_PS, CLK_PS);
  localparam int SHORT_MAX = imax(imax(imax(RCD_C, RAS_C), imax(RC_C, RRD_C)),
                                  imax(imax(BURST_CLK + RP_C, BURST_CLK + WR_C), MRD_CLK));
  localparam int CNT_W    = $clog2(SHORT_MAX + 1);

  op_e op;
  assign op = op_e'(cmd_op);

  logic [NBANK-1:0] ev_act, ev_wr, ev_ap, ev_close;
  logic [NBANK-1:0] open_v, rcd_v, rp_v, ras_v, rc_v, wr_v, over_v;
  logic             rrd_busy, mrd_busy;
  logic [RSN_W-1:0] rsn, set_vec;

  for (genvar i = 0; i < NBANK; i++) begin : g_bank
    logic hit;
    assign hit         = (cmd_bank == BANK_W'(i));
    assign ev_act[i]   = cmd_valid && (op == OP_ACT) && hit;
    assign ev_wr[i]    = cmd_valid && (op == OP_WR) && hit;
    assign ev_ap[i]    = cmd_valid && ((op == OP_RD) || (op == OP_WR)) && cmd_ap && hit;
    assign ev_close[i] = cmd_valid && (op == OP_PRE) && (cmd_ap || hit) && open_v[i];

    ddr_tg_bank #(
      .RCD_C(RCD_C), .RP_C(RP_C), .RAS_C(RAS_C), .RC_C(RC_C), .WR_C(WR_C),
      .BURST_C(BURST_CLK), .RASMAX_C(RASMAX_C), .CNT_W(CNT_W)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .ev_act(ev_act[i]), .ev_wr(ev_wr[i]), .ev_ap(ev_ap[i]), .ev_close(ev_close[i]),
      .open_o(open_v[i]), .rcd_busy_o(rcd_v[i]), .rp_busy_o(rp_v[i]),
      .ras_busy_o(ras_v[i]), .rc_busy_o(rc_v[i]), .wr_busy_o(wr_v[i]),
      .ras_over_o(over_v[i])
    );
  end

  ddr_tg_global #(
    .RRD_C(RRD_C), .MRD_C(MRD_CLK), .CNT_W(CNT_W)
  ) u_global (
    .clk(clk), .rst_n(rst_n),
    .ev_act_any(|ev_act),
    .ev_mrs(cmd_valid && (op == OP_MRS)),
    .rrd_busy_o(rrd_busy),
    .mrd_busy_o(mrd_busy)
  );

  always_comb begin
    rsn = '0;
    case (op)
      OP_ACT: begin
        rsn[RSN_STATE] = open_v[cmd_bank];
        rsn[RSN_RP]    = rp_v[cmd_bank];
        rsn[RSN_RC]    = rc_v[cmd_bank];
        rsn[RSN_RRD]   = rrd_busy;
      end
      OP_RD, OP_WR: begin
        rsn[RSN_STATE] = !open_v[cmd_bank];
        rsn[RSN_RCD]   = open_v[cmd_bank] && rcd_v[cmd_bank];
      end
      OP_PRE: begin
        for (int i = 0; i < NBANK; i++) begin
          if ((cmd_ap || (cmd_bank == BANK_W'(i))) && open_v[i]) begin
            rsn[RSN_RAS] = rsn[RSN_RAS] | ras_v[i];
            rsn[RSN_WR]  = rsn[RSN_WR]  | wr_v[i];
          end
        end
      end
      OP_MRS: rsn[RSN_MODE] = |open_v;
      default: ;
    endcase
    if (mrd_busy && (op inside {OP_ACT, OP_RD, OP_WR, OP_PRE, OP_MRS}))
      rsn[RSN_MODE] = 1'b1;
  end

  assign cmd_legal = ~|rsn;

  always_comb begin
    set_vec = cmd_valid ? rsn : '0;
    set_vec[RSN_RASMAX] = |over_v;
  end

  ddr_tg_sticky #(.W(RSN_W)) u_sticky (
    .clk(clk), .rst_n(rst_n), .clr(viol_clr), .set_i(set_vec),
    .reason_o(viol_reason), .flag_o(viol_flag)
  );

  // R1: an issued illegal command is always recorded
  assert_illegal_recorded_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_legal) |=> viol_flag);

  // R10: a read or write never sees a legal verdict on a closed bank
  assert_closed_column_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (((op == OP_RD) || (op == OP_WR)) && !open_v[cmd_bank]) |-> !cmd_legal);

endmodule

// File: tb/ddr_bank_timing_guard_bench.sv
module ddr_bank_timing_guard_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_op = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ap = 1'b0;
  logic       cmd_legal;
  logic       viol_clr = 1'b0;
  logic       viol_flag;
  logic [8:0] viol_reason;

  int n_chk = 0;
  int n_fail = 0;
  logic probe_legal;

  localparam logic [2:0] NOP = 3'd0, ACT = 3'd1, RD = 3'd2, WR = 3'd3, PRE = 3'd4, MRS = 3'd5;
  localparam int RASMAX_CLK = 16000;

  always #5 clk = ~clk;

  ddr_bank_timing_guard u_ddr_bank_timing_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cmd_legal(cmd_legal),
    .viol_clr(viol_clr), .viol_flag(viol_flag), .viol_reason(viol_reason)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // one cycle: drive at negedge, sample verdict, let the edge pass
  task automatic drive(input logic [2:0] op, input logic [1:0] bk, input logic ap, input logic v);
    @(negedge clk);
    cmd_op = op; cmd_bank = bk; cmd_ap = ap; cmd_valid = v;
    #1 probe_legal = cmd_legal;
    @(posedge clk);
    #1 cmd_valid = 1'b0; cmd_op = NOP;
  endtask

  task automatic issue(input logic [2:0] op, input logic [1:0] bk, input logic ap);
    drive(op, bk, ap, 1'b1);
  endtask

  task automatic probe(input logic [2:0] op, input logic [1:0] bk, input logic ap,
                       input logic exp, input string req, input string what);
    drive(op, bk, ap, 1'b0);
    chk(req, what, probe_legal, exp);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(NOP, 2'd0, 1'b0, 1'b0);
  endtask

  task automatic clear_pulse();
    @(negedge clk); viol_clr = 1'b1;
    @(posedge clk); #1 viol_clr = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = NOP; viol_clr = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R13", "reason after reset", viol_reason, 9'h000);
    chk("R13", "flag after reset", viol_flag, 1'b0);
    probe(ACT, 2'd0, 1'b0, 1'b1, "R1", "activate legal from reset");
    probe(RD, 2'd0, 1'b0, 1'b0, "R10", "read of closed bank");
    chk("R1", "probing never records", viol_reason, 9'h000);
  endtask

  task automatic t_rcd();
    do_reset();
    issue(ACT, 2'd0, 1'b0);
    probe(RD, 2'd0, 1'b0, 1'b0, "R3", "read at +1");
    probe(WR, 2'd0, 1'b0, 1'b0, "R3", "write at +2");
    probe(RD, 2'd0, 1'b0, 1'b1, "R3", "read at +3");
  endtask

  task automatic t_rrd_ras_rc();
    do_reset();
    issue(ACT, 2'd0, 1'b0);
    probe(ACT, 2'd1, 1'b0, 1'b0, "R7", "other bank act at +1");
    probe(ACT, 2'd1, 1'b0, 1'b1, "R7", "other bank act at +2");
    idle(2);
    probe(PRE, 2'd0, 1'b0, 1'b0, "R5", "precharge at +5");
    issue(PRE, 2'd0, 1'b0);
    chk("R5", "precharge at +6 verdict", probe_legal, 1'b1);
    idle(1);
    issue(ACT, 2'd0, 1'b0);
    chk("R6", "reasons for act at +8", viol_reason, 9'h00A);
    do_reset();
    issue(ACT, 2'd0, 1'b0);
    idle(5);
    issue(PRE, 2'd0, 1'b0);
    idle(1);
    probe(ACT, 2'd0, 1'b0, 1'b0, "R2", "row cycle not truncated at +8");
    probe(ACT, 2'd0, 1'b0, 1'b1, "R6", "row cycle met at +9");
  endtask

  task automatic t_rp();
    do_reset();
    issue(ACT, 2'd1, 1'b0);
    idle(19);
    issue(PRE, 2'd1, 1'b0);
    probe(ACT, 2'd1, 1'b0, 1'b0, "R4", "act 1 after precharge");
    probe(ACT, 2'd1, 1'b0, 1'b0, "R4", "act 2 after precharge");
    probe(ACT, 2'd1, 1'b0, 1'b1, "R4", "act 3 after precharge");
  endtask

  task automatic t_write_recovery();
    do_reset();
    issue(ACT, 2'd2, 1'b0);
    idle(2);
    issue(WR, 2'd2, 1'b0);
    idle(2);
    probe(PRE, 2'd2, 1'b0, 1'b0, "R8", "precharge 3 after write");
    probe(PRE, 2'd2, 1'b0, 1'b1, "R8", "precharge 4 after write");
    drive(PRE, 2'd2, 1'b0, 1'b1);
    drive(PRE, 2'd2, 1'b0, 1'b0);
    do_reset();
    issue(ACT, 2'd2, 1'b0);
    idle(2);
    issue(WR, 2'd2, 1'b0);
    idle(2);
    issue(PRE, 2'd2, 1'b0);
    chk("R8", "early precharge reason", viol_reason, 9'h020);
  endtask

  task automatic t_auto_precharge();
    do_reset();
    issue(ACT, 2'd3, 1'b0);
    idle(4);
    issue(WR, 2'd3, 1'b1);
    probe(RD, 2'd3, 1'b0, 1'b0, "R11", "read after write with auto-precharge");
    idle(2);
    probe(ACT, 2'd3, 1'b0, 1'b0, "R11", "act 4 after auto-precharge write");
    probe(ACT, 2'd3, 1'b0, 1'b1, "R11", "act 5 after auto-precharge write");
  endtask

  task automatic t_mode();
    do_reset();
    issue(MRS, 2'd0, 1'b0);
    probe(ACT, 2'd0, 1'b0, 1'b0, "R9", "act 1 after mode set");
    probe(ACT, 2'd0, 1'b0, 1'b1, "R9", "act 2 after mode set");
    issue(ACT, 2'd0, 1'b0);
    probe(MRS, 2'd0, 1'b0, 1'b0, "R9", "mode set with open bank");
    issue(MRS, 2'd0, 1'b0);
    chk("R9", "mode reason", viol_reason, 9'h040);
    clear_pulse();
    chk("R13", "cleared after pulse", viol_reason, 9'h000);
  endtask

  task automatic t_sticky();
    do_reset();
    issue(RD, 2'd1, 1'b0);
    chk("R10", "closed read reason", viol_reason, 9'h080);
    chk("R13", "flag raised", viol_flag, 1'b1);
    idle(5);
    chk("R13", "reason held", viol_reason, 9'h080);
    clear_pulse();
    chk("R13", "reason cleared", viol_reason, 9'h000);
    chk("R13", "flag cleared", viol_flag, 1'b0);
  endtask

  task automatic t_precharge_all();
    do_reset();
    issue(ACT, 2'd0, 1'b0);
    idle(1);
    issue(ACT, 2'd1, 1'b0);
    idle(3);
    probe(PRE, 2'd0, 1'b1, 1'b0, "R14", "all-banks precharge at +6");
    probe(PRE, 2'd0, 1'b1, 1'b0, "R14", "all-banks precharge at +7");
    probe(PRE, 2'd3, 1'b1, 1'b1, "R14", "all-banks precharge at +8");
    issue(PRE, 2'd3, 1'b1);
    probe(RD, 2'd0, 1'b0, 1'b0, "R14", "bank 0 closed by all-banks");
    probe(RD, 2'd1, 1'b0, 1'b0, "R14", "bank 1 closed by all-banks");
    issue(PRE, 2'd2, 1'b0);
    probe(ACT, 2'd2, 1'b0, 1'b1, "R14", "precharge of closed bank starts no timer");
    chk("R14", "no reason recorded", viol_reason, 9'h000);
  endtask

  task automatic t_ras_max();
    do_reset();
    issue(ACT, 2'd0, 1'b0);
    idle(RASMAX_CLK);
    chk("R12", "row at limit not flagged", viol_reason, 9'h000);
    idle(1);
    chk("R12", "row past limit flagged", viol_reason, 9'h100);
  endtask

  initial begin
    t_reset_state();
    t_rcd();
    t_rrd_ras_rc();
    t_rp();
    t_write_recovery();
    t_auto_precharge();
    t_mode();
    t_sticky();
    t_precharge_all();
    t_ras_max();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule